// File: doc/BRIEF.md
# Timer Compare Waveform Generator

This block is an 8-bit timer-counter with two compare channels, A and B. Each channel drives one waveform output pin. A 3-bit mode field picks how the counter runs: a free-running wrap, a clear at a compare limit, a single-slope PWM ramp, or a dual-slope triangle for phase-correct PWM. Each channel has a 2-bit output action field. That field, combined with the count mode and the count direction, decides how the channel's waveform register responds to a compare match, to the count reaching zero (BOTTOM) and to the count reaching its limit (TOP).

Software sets the block up through a small write port with three registers: a control byte, compare value A and compare value B. When a channel's action field connects it, the waveform register replaces the ordinary port value on that pin. When the channel is disconnected, the ordinary port value passes through. Each pin's driver enable follows its direction bit.

Every pin is a plain level, and a write takes effect on a single clock edge. The block therefore has no streaming data path and no valid/ready handshake. All pins are simple control and status lines with no back-pressure.

Top module: `tcwg_top`

## Requirements
- R1: A synchronous reset clears the count, both waveform registers, the control byte and both compare values. After reset the count is 0, both overrides are low, and each pin equals its ordinary port value.
- R2: The mode code sits in control bits [1:0]: 00 free-run, 10 clear-on-limit, 11 single-slope PWM, 01 dual-slope PWM. Control bit [2] selects compare A as TOP in the two PWM modes. Clear-on-limit always uses compare A as TOP. In every other case TOP is 0xFF. Free-run wraps from 0xFF to 0. Clear-on-limit and single-slope PWM go to 0 on the edge after the count is at or above TOP, and otherwise add one.
- R3: In free-run and clear-on-limit, a channel's action field (A in control bits [7:6], B in bits [5:4]) works as follows on a compare match (count equals that channel's compare value): 00 disconnects the channel, 01 toggles the waveform, 10 clears it, 11 sets it.
- R4: Dual-slope PWM counts up from 0 to TOP and then down to 0. The direction reverses at each end, so each extreme value appears for exactly one clock.
- R5: In single-slope PWM, field 10 clears the waveform on a match and sets it at BOTTOM. Field 11 sets it on a match and clears it at BOTTOM. When a match and BOTTOM fall on the same count, the match action wins.
- R6: In dual-slope PWM, field 10 clears the waveform on a match while counting up and sets it on a match while counting down. Field 11 does the reverse. The count at TOP is treated as counting up, and the count at 0 as counting down.
- R7: In both PWM modes, field 01 on channel A toggles the waveform on a match when control bit [2] is 1, and disconnects the channel when that bit is 0. Field 01 on channel B always disconnects it in PWM modes.
- R8: In single-slope PWM, when compare A equals TOP and channel A's field is 10 or 11, channel A ignores its match and changes only at BOTTOM.
- R9: In dual-slope PWM, when compare A equals TOP and channel A's field is 10 or 11, channel A ignores its match and acts only at TOP: field 10 clears the waveform and field 11 sets it.
- R10: A channel's override output is high exactly when its field connects it (R3, R5, R6, R7). Its pin then shows the waveform register; otherwise the pin shows the ordinary port value.
- R11: Each driver enable output equals that pin's direction input.
- R12: A write with select 0 loads the control byte, select 1 loads compare A, select 2 loads compare B, and select 3 changes nothing. The new value governs behaviour from the next clock edge. Reset takes priority over a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 compare A, 2 compare B |
| wr_data | input | 8 | Write data |
| dir_a | input | 1 | Direction bit of pin A (1 = output) |
| dir_b | input | 1 | Direction bit of pin B (1 = output) |
| port_a | input | 1 | Ordinary port output value of pin A |
| port_b | input | 1 | Ordinary port output value of pin B |
| count | output | 8 | Current counter value |
| pin_a | output | 1 | Pin A output value |
| pin_b | output | 1 | Pin B output value |
| ovr_a | output | 1 | Channel A overrides the port function |
| ovr_b | output | 1 | Channel B overrides the port function |
| drv_a | output | 1 | Pin A driver enable |
| drv_b | output | 1 | Pin B driver enable |

## Verification
The assertions assume that reset is held at the first clock, so the count and the direction flag start from known values. The dual-slope properties also assume that TOP is nonzero while that mode runs. The stimulus resets the block before every configuration. It writes compare A only with nonzero values when A serves as TOP. It changes registers only between runs, never in the middle of one. The port values and direction bits move freely on every cycle, and this is legal because they feed only the pin multiplexer and the driver enables.

// File: rtl/tcwg_pkg.sv
package tcwg_pkg;
  localparam int CNT_W = 8;

  typedef enum logic [1:0] {
    MODE_FREE  = 2'b00,
    MODE_DUAL  = 2'b01,
    MODE_LIMIT = 2'b10,
    MODE_SLOPE = 2'b11
  } cnt_mode_t;

  typedef enum logic [1:0] {
    ACT_OFF = 2'b00,
    ACT_TOG = 2'b01,
    ACT_CLR = 2'b10,
    ACT_SET = 2'b11
  } out_act_t;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CMPA = 2'd1,
    SEL_CMPB = 2'd2,
    SEL_NONE = 2'd3
  } wr_sel_t;
endpackage

// File: rtl/tcwg_regs.sv
module tcwg_regs
  import tcwg_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output cnt_mode_t    mode_lo,
  output logic         mode_hi,
  output out_act_t     act_a,
  output out_act_t     act_b,
  output logic [W-1:0] cmp_a,
  output logic [W-1:0] cmp_b
);
  logic [7:0]   ctrl_q;
  logic [W-1:0] cmpa_q, cmpb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
    end else if (wr_en) begin
      unique case (wr_sel_t'(wr_sel))
        SEL_CTRL: ctrl_q <= wr_data[7:0];
        SEL_CMPA: cmpa_q <= wr_data;
        SEL_CMPB: cmpb_q <= wr_data;
        default:  ;
      endcase
    end
  end

  assign mode_lo = cnt_mode_t'(ctrl_q[1:0]);
  assign mode_hi = ctrl_q[2];
  assign act_b   = out_act_t'(ctrl_q[5:4]);
  assign act_a   = out_act_t'(ctrl_q[7:6]);
  assign cmp_a   = cmpa_q;
  assign cmp_b   = cmpb_q;

  // R12: select 3 leaves every register as it was
  a_r12_sel_none_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd3) |=> ($stable(ctrl_q) && $stable(cmpa_q) && $stable(cmpb_q)));
endmodule

// File: rtl/tcwg_counter.sv
module tcwg_counter
  import tcwg_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  cnt_mode_t    mode_lo,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         up,
  output logic         at_top,
  output logic         at_bottom
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         up_q, up_d;

  always_comb begin
    cnt_d = cnt_q + ONE;
    up_d  = 1'b1;
    unique case (mode_lo)
      MODE_FREE: cnt_d = cnt_q + ONE;
      MODE_LIMIT, MODE_SLOPE: begin
        if (cnt_q >= top) cnt_d = '0;
      end
      MODE_DUAL: begin
        if (up_q) begin
          if (cnt_q >= top) begin
            up_d  = 1'b0;
            cnt_d = (top == '0) ? '0 : top - ONE;
          end else begin
            up_d  = 1'b1;
            cnt_d = cnt_q + ONE;
          end
        end else begin
          if (cnt_q == '0) begin
            up_d  = 1'b1;
            cnt_d = (top == '0) ? '0 : ONE;
          end else begin
            up_d  = 1'b0;
            cnt_d = cnt_q - ONE;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt       = cnt_q;
  assign up        = up_q;
  assign at_top    = (cnt_q == top);
  assign at_bottom = (cnt_q == '0);

  // R2: clear-on-limit returns to zero once TOP is reached
  a_r2_limit_wrap: assert property (@(posedge clk) disable iff (rst)
    (mode_lo == MODE_LIMIT && cnt_q >= top) |=> (cnt_q == '0));
  // R4: dual slope turns upward after touching zero
  a_r4_dual_turn_up: assert property (@(posedge clk) disable iff (rst)
    (mode_lo == MODE_DUAL && !up_q && cnt_q == '0) |=> up_q);
  // R4: dual slope moves by exactly one between consecutive counts
  a_r4_dual_step: assert property (@(posedge clk) disable iff (rst)
    (mode_lo == MODE_DUAL && top != '0 && $past(mode_lo) == MODE_DUAL && cnt_q <= top && $past(cnt_q) <= $past(top))
      |=> (cnt_q == $past(cnt_q) + ONE || cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/tcwg_channel.sv
module tcwg_channel
  import tcwg_pkg::*;
#(
  parameter int W          = CNT_W,
  parameter bit IS_PRIMARY = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  cnt_mode_t    mode_lo,
  input  logic         mode_hi,
  input  out_act_t     act,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  logic [W-1:0] top,
  input  logic         up,
  input  logic         at_top,
  input  logic         at_bottom,
  output logic         wave,
  output logic         connected
);
  logic match, skip_match;
  logic do_set, do_clr, do_tog;
  logic wave_q;

  assign match = (cnt == cmp);

  generate
    if (IS_PRIMARY) begin : g_primary
      assign skip_match = act[1] && (cmp == top);
    end else begin : g_secondary
      assign skip_match = 1'b0;
    end
  endgenerate

  always_comb begin
    do_set    = 1'b0;
    do_clr    = 1'b0;
    do_tog    = 1'b0;
    connected = 1'b0;
    unique case (mode_lo)
      MODE_FREE, MODE_LIMIT: begin
        connected = (act != ACT_OFF);
        if (match) begin
          do_tog = (act == ACT_TOG);
          do_clr = (act == ACT_CLR);
          do_set = (act == ACT_SET);
        end
      end
      MODE_SLOPE: begin
        if (act == ACT_TOG) begin
          connected = IS_PRIMARY && mode_hi;
          do_tog    = connected && match;
        end else if (act != ACT_OFF) begin
          connected = 1'b1;
          if (match && !skip_match) begin
            do_clr = (act == ACT_CLR);
            do_set = (act == ACT_SET);
          end else if (at_bottom) begin
            do_set = (act == ACT_CLR);
            do_clr = (act == ACT_SET);
          end
        end
      end
      MODE_DUAL: begin
        if (act == ACT_TOG) begin
          connected = IS_PRIMARY && mode_hi;
          do_tog    = connected && match;
        end else if (act != ACT_OFF) begin
          connected = 1'b1;
          if (skip_match) begin
            if (at_top) begin
              do_clr = (act == ACT_CLR);
              do_set = (act == ACT_SET);
            end
          end else if (match) begin
            if (up == (act == ACT_CLR)) do_clr = 1'b1;
            else                        do_set = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         wave_q <= 1'b0;
    else if (do_tog) wave_q <= ~wave_q;
    else if (do_set) wave_q <= 1'b1;
    else if (do_clr) wave_q <= 1'b0;
  end

  assign wave = wave_q;

  // R3: toggle action inverts the waveform on a match
  a_r3_toggle_match: assert property (@(posedge clk) disable iff (rst)
    ((mode_lo == MODE_FREE || mode_lo == MODE_LIMIT) && act == ACT_TOG && match) |=> (wave_q != $past(wave_q)));
  // R5: non-inverting single slope is high after BOTTOM without a match
  a_r5_slope_bottom_set: assert property (@(posedge clk) disable iff (rst)
    (mode_lo == MODE_SLOPE && act == ACT_CLR && at_bottom && !match) |=> wave_q);
  // R6: dual slope non-inverting clears on an up-count match
  a_r6_dual_up_clear: assert property (@(posedge clk) disable iff (rst)
    (mode_lo == MODE_DUAL && act == ACT_CLR && match && up && !skip_match) |=> !wave_q);
  // R10: a disconnected channel never moves its waveform
  a_r10_off_hold: assert property (@(posedge clk) disable iff (rst)
    (!connected) |=> $stable(wave_q));
endmodule

// File: rtl/tcwg_top.sv
module tcwg_top
  import tcwg_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         dir_a,
  input  logic         dir_b,
  input  logic         port_a,
  input  logic         port_b,
  output logic [W-1:0] count,
  output logic         pin_a,
  output logic         pin_b,
  output logic         ovr_a,
  output logic         ovr_b,
  output logic         drv_a,
  output logic         drv_b
);
  localparam int NCH = 2;

  cnt_mode_t    mode_lo;
  logic         mode_hi;
  out_act_t     act_a, act_b;
  logic [W-1:0] cmp_a, cmp_b, top;
  logic [W-1:0] cnt;
  logic         up, at_top, at_bottom;
  logic         top_from_a;

  out_act_t     ch_act  [NCH];
  logic [W-1:0] ch_cmp  [NCH];
  logic [NCH-1:0] ch_wave, ch_conn, ch_port, ch_pin;

  tcwg_regs #(.W(W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .mode_lo(mode_lo), .mode_hi(mode_hi), .act_a(act_a), .act_b(act_b),
    .cmp_a(cmp_a), .cmp_b(cmp_b)
  );

  assign top_from_a = (mode_lo == MODE_LIMIT) ||
                      (mode_hi && (mode_lo == MODE_SLOPE || mode_lo == MODE_DUAL));
  assign top = top_from_a ? cmp_a : '1;

  tcwg_counter #(.W(W)) cnt_i (
    .clk(clk), .rst(rst), .mode_lo(mode_lo), .top(top),
    .cnt(cnt), .up(up), .at_top(at_top), .at_bottom(at_bottom)
  );

  assign ch_act[0]  = act_a;
  assign ch_act[1]  = act_b;
  assign ch_cmp[0]  = cmp_a;
  assign ch_cmp[1]  = cmp_b;
  assign ch_port    = {port_b, port_a};

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      tcwg_channel #(.W(W), .IS_PRIMARY(g == 0)) ch_i (
        .clk(clk), .rst(rst), .mode_lo(mode_lo), .mode_hi(mode_hi),
        .act(ch_act[g]), .cnt(cnt), .cmp(ch_cmp[g]), .top(top), .up(up),
        .at_top(at_top), .at_bottom(at_bottom),
        .wave(ch_wave[g]), .connected(ch_conn[g])
      );
      assign ch_pin[g] = ch_conn[g] ? ch_wave[g] : ch_port[g];
    end
  endgenerate

  assign count = cnt;
  assign pin_a = ch_pin[0];
  assign pin_b = ch_pin[1];
  assign ovr_a = ch_conn[0];
  assign ovr_b = ch_conn[1];
  assign drv_a = dir_a;
  assign drv_b = dir_b;

  // R7: channel B in a PWM mode with the toggle code stays on the port
  a_r7_b_tog_pwm_off: assert property (@(posedge clk) disable iff (rst)
    ((mode_lo == MODE_SLOPE || mode_lo == MODE_DUAL) && act_b == ACT_TOG) |-> (pin_b == port_b));
  // R1: one cycle after reset both channels are released
  a_r1_reset_release: assert property (@(posedge clk)
    $past(rst) |-> (!ovr_a && !ovr_b && count == '0));
endmodule

// File: tb/tcwg_top_tb_top.sv
module tcwg_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       dir_a = 1'b0, dir_b = 1'b0, port_a = 1'b0, port_b = 1'b0;
  logic [7:0] count;
  logic       pin_a, pin_b, ovr_a, ovr_b, drv_a, drv_b;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  tcwg_top dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .dir_a(dir_a), .dir_b(dir_b), .port_a(port_a), .port_b(port_b),
    .count(count), .pin_a(pin_a), .pin_b(pin_b), .ovr_a(ovr_a), .ovr_b(ovr_b),
    .drv_a(drv_a), .drv_b(drv_b)
  );

  // reference state
  logic [7:0] m_cnt = 0, m_ctrl = 0, m_ca = 0, m_cb = 0;
  logic       m_up = 1, m_wa = 0, m_wb = 0;

  function automatic bit ref_conn(bit is_a, logic [1:0] f, logic [1:0] md, bit hi);
    if (f == 2'b00) return 0;
    if (md == 2'b00 || md == 2'b10) return 1;
    if (f == 2'b01) return is_a && hi;
    return 1;
  endfunction

  function automatic logic ref_wave(bit is_a, logic w, logic [1:0] f, logic [1:0] md, bit hi,
                                    bit match, bit bot, bit attop, bit up, bit ign);
    if (!ref_conn(is_a, f, md, hi)) return w;
    if (md == 2'b00 || md == 2'b10) begin
      if (!match) return w;
      if (f == 2'b01) return ~w;
      return (f == 2'b11);
    end
    if (f == 2'b01) return match ? ~w : w;
    if (md == 2'b11) begin
      if (match && !ign) return (f == 2'b11);
      if (bot) return (f == 2'b10);
      return w;
    end
    if (ign) return attop ? (f == 2'b11) : w;
    if (match) return up ? (f == 2'b11) : (f == 2'b10);
    return w;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_up = 1; m_wa = 0; m_wb = 0; m_ctrl = 0; m_ca = 0; m_cb = 0;
    end else begin
      logic [1:0] md;
      logic [7:0] top;
      bit hi, pwm, bot, attop, ign;
      md  = m_ctrl[1:0];
      hi  = m_ctrl[2];
      pwm = (md == 2'b01 || md == 2'b11);
      top = (md == 2'b10 || (pwm && hi)) ? m_ca : 8'hFF;
      bot = (m_cnt == 0);
      attop = (m_cnt == top);
      ign = m_ctrl[7] && (m_ca == top);
      m_wa = ref_wave(1, m_wa, m_ctrl[7:6], md, hi, m_cnt == m_ca, bot, attop, m_up, ign);
      m_wb = ref_wave(0, m_wb, m_ctrl[5:4], md, hi, m_cnt == m_cb, bot, attop, m_up, 0);
      if (md == 2'b00) begin
        m_cnt = m_cnt + 1; m_up = 1;
      end else if (md != 2'b01) begin
        m_cnt = (m_cnt >= top) ? 8'd0 : m_cnt + 1; m_up = 1;
      end else if (m_up) begin
        if (m_cnt >= top) begin m_up = 0; m_cnt = (top == 0) ? 8'd0 : top - 1; end
        else m_cnt = m_cnt + 1;
      end else begin
        if (m_cnt == 0) begin m_up = 1; m_cnt = (top == 0) ? 8'd0 : 8'd1; end
        else m_cnt = m_cnt - 1;
      end
      if (wr_en) begin
        if (wr_sel == 0) m_ctrl = wr_data;
        else if (wr_sel == 1) m_ca = wr_data;
        else if (wr_sel == 2) m_cb = wr_data;
      end
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    bit ca, cb;
    ca = ref_conn(1, m_ctrl[7:6], m_ctrl[1:0], m_ctrl[2]);
    cb = ref_conn(0, m_ctrl[5:4], m_ctrl[1:0], m_ctrl[2]);
    check(tag, "count", count, m_cnt);
    check({tag, " R10"}, "ovr_a", ovr_a, ca);
    check({tag, " R10"}, "ovr_b", ovr_b, cb);
    check({tag, " R10"}, "pin_a", pin_a, ca ? m_wa : port_a);
    check({tag, " R10"}, "pin_b", pin_b, cb ? m_wb : port_b);
    check("R11", "drv_a", drv_a, dir_a);
    check("R11", "drv_b", drv_b, dir_b);
  endtask

  task automatic cycle(string tag, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare(tag);
      port_a = $urandom_range(0, 1);
      port_b = $urandom_range(0, 1);
      dir_a  = $urandom_range(0, 1);
      dir_b  = $urandom_range(0, 1);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic setup(logic [2:0] md, logic [1:0] fa, logic [1:0] fb, logic [7:0] ca, logic [7:0] cb);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    wr(2'd1, ca);
    wr(2'd2, cb);
    wr(2'd0, {fa, fb, 1'b0, md});
  endtask

  initial begin
    rst = 1;
    repeat (2) @(negedge clk);
    // R1: reset state while write is also requested (reset wins, R12)
    wr_en = 1; wr_sel = 0; wr_data = 8'hFF; port_a = 1; port_b = 0;
    @(negedge clk);
    check("R1", "count", count, 0);
    check("R1", "ovr_a", ovr_a, 0);
    check("R1", "ovr_b", ovr_b, 0);
    check("R1", "pin_a", pin_a, 1);
    check("R12", "pin_b", pin_b, 0);
    wr_en = 0; rst = 0;
    cycle("R1", 4);

    setup(3'b000, 2'b01, 2'b10, 8'd10, 8'd20);   cycle("R3 R2 free", 600);
    wr(2'd3, 8'h55);                              cycle("R12 none", 20);
    setup(3'b010, 2'b11, 2'b01, 8'd40, 8'd15);   cycle("R3 R2 limit", 200);
    setup(3'b011, 2'b10, 2'b11, 8'd100, 8'd0);   cycle("R5 slope", 600);
    setup(3'b111, 2'b10, 2'b10, 8'd50, 8'd20);   cycle("R8 slope top", 200);
    setup(3'b111, 2'b11, 2'b11, 8'd50, 8'd50);   cycle("R8 slope top inv", 200);
    setup(3'b111, 2'b01, 2'b01, 8'd60, 8'd30);   cycle("R7 tog on", 200);
    setup(3'b011, 2'b01, 2'b01, 8'd60, 8'd30);   cycle("R7 tog off", 300);
    setup(3'b001, 2'b10, 2'b11, 8'd80, 8'd200);  cycle("R6 R4 dual", 1100);
    setup(3'b101, 2'b11, 2'b10, 8'd70, 8'd30);   cycle("R9 dual top", 400);
    setup(3'b101, 2'b10, 2'b01, 8'd70, 8'd0);    cycle("R9 dual top clr", 400);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule